// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory. A 128-byte array made of registers sits behind an I2C-style bus. The bus is modelled as an open-drain pair: the block reads the bus level on `sdaIn`. When `sdaOe` is high it pulls the data line low. The clock line arrives on `sclIn` and is synchronised to the system clock `clk`. All bus decoding is done on the synchronised edges: START, STOP, the device address byte with its direction bit, the word address byte, the data bytes and the acknowledge slots.

A write sets the internal address counter from the word address byte. It then stores each following data byte. The counter steps only within the current 16-byte page. A read needs no word address. It returns bytes from the counter, which holds the last accessed location plus one, and it keeps streaming while the master acknowledges. To read from a chosen location, the master writes the word address, issues a repeated START and reads. The counter keeps its value between transactions. The `writeAllow` input, when low, turns the array read-only.

Top module: `eep_i2c_slave`

## Requirements
- R1: A START (data falls while clock is high) in any state begins a new device address byte. A STOP (data rises while clock is high) returns the block to idle. A data byte cut short by either condition is never written.
- R2: In the device address byte, bits 7:4 must equal 4'b1010, bits 3:1 are not compared, and bit 0 selects read (1) or write (0). On a mismatch there is no ACK, and the bus is ignored until the next START.
- R3: The slave ACKs a matching device address, a word address and every write data byte. It does so by holding `sdaOe` high from the clock fall after the eighth bit to the clock fall after the ninth. It never drives while the master sends bits.
- R4: The word address byte bits 6:0 load the address counter. Each data byte is stored at the counter. Then only the counter's low 4 bits increment, wrapping inside the page, so a 17th byte overwrites the first.
- R5: While `writeAllow` is low, data bytes are still ACKed and the counter still steps, but the array keeps its contents.
- R6: A read sends the byte at the counter MSB first. `sdaOe` is the inverse of each bit and changes after each clock fall. The counter increments by one per byte and wraps from 127 to 0.
- R7: A master ACK (data low on the ninth clock) after a read byte starts the next byte. A master NACK makes the slave release the line and stay off until the next START.
- R8: A write of a word address followed by a repeated START and a read address returns data starting at that word address.
- R9: The counter survives STOP. A read without a word address continues from the last accessed byte plus one.
- R10: After reset `sdaOe` is 0, the counter is 0 and every array byte is 0. `sdaOe` stays 0 while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line, asynchronous |
| sdaIn | input | 1 | Bus data line level, asynchronous |
| writeAllow | input | 1 | High allows array writes; low makes the array read-only |
| sdaOe | output | 1 | High pulls the bus data line low |

## Verification
Most internal faults reach the single output `sdaOe`. A bus state machine in the wrong phase shows up as an ACK in the wrong slot, or as a missing ACK, within one SCL period of the fault. A wrong address counter, page wrap or lost write stays hidden until the next read. That read then returns a wrong byte, bit by bit, on `sdaOe`. The bench therefore follows every write with reads that cover the page wrap, the 127-to-0 wrap, the protected location and the location of the aborted byte. It also compares `sdaOe` on every clock against the expected level for the current bit.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_RDATA
  } busState_t;

  typedef struct packed {
    logic loadAddr;
    logic writeByte;
    logic readAdv;
  } dpStrobe_t;

endpackage

// File: rtl/eep_bus_ctrl.sv
module eep_bus_ctrl
  import eep_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          DEV_ID_W    = 4,
  parameter logic [3:0]  DEV_ID      = 4'hA
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  input  logic [7:0]      rdData,
  output dpStrobe_t       strb,
  output logic [7:0]      wrData,
  output logic            sdaOe
);

  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_SLOT = 4'd9;
  localparam logic [3:0] CNT_ONE  = 4'd1;

  logic [SYNC_STAGES:0] sclSync, sdaSync;
  logic sclNow, sclOld, sdaNow, sdaOld;
  logic sclRise, sclFall, startDet, stopDet, busEvent;
  busState_t state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic rwBit, masterAck, idMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-1:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclNow   = sclSync[SYNC_STAGES-1];
  assign sclOld   = sclSync[SYNC_STAGES];
  assign sdaNow   = sdaSync[SYNC_STAGES-1];
  assign sdaOld   = sdaSync[SYNC_STAGES];
  assign sclRise  = sclNow & ~sclOld;
  assign sclFall  = ~sclNow & sclOld;
  assign startDet = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopDet  = sclNow & sclOld & ~sdaOld & sdaNow;
  assign busEvent = startDet | stopDet;
  assign idMatch  = (shiftReg[7 -: DEV_ID_W] == DEV_ID[DEV_ID_W-1:0]);
  assign wrData   = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      sdaOe     <= 1'b0;
      rwBit     <= 1'b0;
      masterAck <= 1'b0;
    end else if (startDet) begin
      state  <= ST_DEV;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt < LAST_BIT) begin
          bitCnt <= bitCnt + CNT_ONE;
          if (state != ST_RDATA) shiftReg <= {shiftReg[6:0], sdaNow};
        end else if (bitCnt == ACK_SLOT) begin
          masterAck <= ~sdaNow;
        end
      end else if (sclFall) begin
        if (bitCnt == LAST_BIT) begin
          bitCnt <= ACK_SLOT;
          case (state)
            ST_DEV: begin
              if (idMatch) begin
                sdaOe <= 1'b1;
                rwBit <= shiftReg[0];
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_RDATA: sdaOe <= 1'b0;
            default:  sdaOe <= 1'b1;
          endcase
        end else if (bitCnt == ACK_SLOT) begin
          bitCnt <= '0;
          if (state == ST_RDATA && !masterAck) begin
            state <= ST_IDLE;
            sdaOe <= 1'b0;
          end else if ((state == ST_DEV && rwBit) || state == ST_RDATA) begin
            state    <= ST_RDATA;
            shiftReg <= rdData;
            sdaOe    <= ~rdData[7];
          end else begin
            sdaOe <= 1'b0;
            state <= (state == ST_DEV) ? ST_WORD : ST_WDATA;
          end
        end else if (state == ST_RDATA && bitCnt != '0) begin
          shiftReg <= {shiftReg[6:0], 1'b0};
          sdaOe    <= ~shiftReg[6];
        end
      end
    end
  end

  always_comb begin
    strb = '0;
    if (!busEvent && sclFall) begin
      if (bitCnt == LAST_BIT) begin
        strb.loadAddr  = (state == ST_WORD);
        strb.writeByte = (state == ST_WDATA);
      end else if (bitCnt == ACK_SLOT) begin
        strb.readAdv = (state == ST_DEV && rwBit) || (state == ST_RDATA && masterAck);
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe); // R10

  AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DEV || state == ST_WORD || state == ST_WDATA) && bitCnt < LAST_BIT) |-> !sdaOe); // R3

  AST_NO_ACK_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && sclFall && !busEvent && bitCnt == LAST_BIT && !idMatch)
      |=> (!sdaOe && state == ST_IDLE)); // R2

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_DEV && bitCnt == '0 && !sdaOe)); // R1

endmodule

// File: rtl/eep_mem_dp.sv
module eep_mem_dp
  import eep_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              writeAllow,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
  localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] addrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
    end else if (strb.loadAddr) begin
      addrCnt <= wrData[ADDR_W-1:0];
    end else if (strb.writeByte) begin
      addrCnt <= {addrCnt[ADDR_W-1:PAGE_W], addrCnt[PAGE_W-1:0] + PAGE_ONE};
    end else if (strb.readAdv) begin
      addrCnt <= addrCnt + ADDR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
    end else if (strb.writeByte && writeAllow) begin
      memArr[addrCnt] <= wrData;
    end
  end

  assign rdData = memArr[addrCnt];

  // Checker support: remember a write attempt's target and old contents.
  logic              chkValid, chkLocked;
  logic [ADDR_W-1:0] chkAddr;
  logic [DATA_W-1:0] chkOld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkValid  <= 1'b0;
      chkLocked <= 1'b0;
      chkAddr   <= '0;
      chkOld    <= '0;
    end else begin
      chkValid  <= strb.writeByte;
      chkLocked <= ~writeAllow;
      chkAddr   <= addrCnt;
      chkOld    <= memArr[addrCnt];
    end
  end

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkLocked) |-> (memArr[chkAddr] == chkOld)); // R5

  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeByte |=> (addrCnt[ADDR_W-1:PAGE_W] == $past(addrCnt[ADDR_W-1:PAGE_W]))); // R4

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.readAdv |=> (addrCnt == $past(addrCnt) + ADDR_ONE)); // R6

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadAddr, strb.writeByte, strb.readAdv})); // R4

endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int         ADDR_W      = 7,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         DEV_ID_W    = 4,
  parameter logic [3:0] DEV_ID      = 4'hA
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic writeAllow,
  output logic sdaOe
);

  dpStrobe_t  strb;
  logic [7:0] wrData;
  logic [7:0] rdData;

  eep_bus_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEV_ID_W   (DEV_ID_W),
    .DEV_ID     (DEV_ID)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rdData(rdData),
    .strb  (strb),
    .wrData(wrData),
    .sdaOe (sdaOe)
  );

  eep_mem_dp #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W),
    .DATA_W(8)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .writeAllow(writeAllow),
    .rdData    (rdData)
  );

endmodule

// File: tb/eep_i2c_slave_test.sv
`timescale 1ns/1ps
module eep_i2c_slave_test;

  localparam int QTR = 4;
  localparam logic [7:0] DEVW = 8'hA0;
  localparam logic [7:0] DEVR = 8'hA1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaDrv = 1'b1;
  logic allow = 1'b1;
  logic sdaOe;
  logic sdaBus;
  logic expOe = 1'b0;
  logic cmpEn = 1'b0;
  logic done = 1'b0;
  int checks = 0;
  int errors = 0;
  logic [7:0] refMem [128];
  int refPtr = 0;

  assign sdaBus = sdaDrv & ~sdaOe;

  always #2 clk = ~clk;

  eep_i2c_slave uut (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (scl),
    .sdaIn     (sdaBus),
    .writeAllow(allow),
    .sdaOe     (sdaOe)
  );

  // Reference: per-clock expected level of the data-line driver
  always begin
    @(posedge clk);
    #1;
    if (cmpEn && !done) begin
      checks++;
      if (sdaOe !== expOe) begin
        errors++;
        $display("FAIL R3/R6/R7/R10 sdaOe per-clock at %0t: actual=%0b expected=%0b", $time, sdaOe, expOe);
      end
    end
  end

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic clkBit(input logic drv, input logic expAfter, output logic seen);
    sdaDrv = drv;
    waitQ();
    scl = 1'b1;
    waitQ();
    seen = sdaBus;
    waitQ();
    scl = 1'b0;
    cmpEn = 1'b0;
    waitQ();
    expOe = expAfter;
    cmpEn = 1'b1;
  endtask

  task automatic startCond();
    sdaDrv = 1'b1;
    waitQ();
    scl = 1'b1;
    waitQ();
    sdaDrv = 1'b0;
    waitQ();
    scl = 1'b0;
    cmpEn = 1'b0;
    waitQ();
    expOe = 1'b0;
    cmpEn = 1'b1;
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0;
    waitQ();
    scl = 1'b1;
    waitQ();
    sdaDrv = 1'b1;
    waitQ();
    waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, input logic ackExp, input logic nextOe, input string tag);
    logic seen;
    for (int i = 7; i >= 1; i--) clkBit(b[i], 1'b0, seen);
    clkBit(b[0], ackExp, seen);
    clkBit(1'b1, nextOe, seen);
    checks++;
    if ((seen == 1'b0) !== ackExp) begin
      errors++;
      $display("FAIL %s ack for byte %02h: actual=%0b expected=%0b", tag, b, (seen == 1'b0), ackExp);
    end
  endtask

  task automatic recvByte(input logic mAck, input logic [7:0] expB, input logic nextOe, input string tag);
    logic seen;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, (i > 0) ? ~expB[i-1] : 1'b0, seen);
      got[i] = seen;
    end
    clkBit(~mAck, nextOe, seen);
    checks++;
    if (got !== expB) begin
      errors++;
      $display("FAIL %s read byte: actual=%02h expected=%02h", tag, got, expB);
    end
  endtask

  function automatic int pageStep(input int p);
    return (p & 8'h70) | ((p + 1) & 15);
  endfunction

  task automatic writeTxn(input logic [7:0] dev, input int addr, input int n, input int seed, input string tag);
    logic [7:0] d;
    startCond();
    sendByte(dev, 1'b1, 1'b0, "R2");
    sendByte(8'(addr), 1'b1, 1'b0, "R3");
    refPtr = addr & 127;
    for (int k = 0; k < n; k++) begin
      d = 8'((seed + k * 37) & 255);
      sendByte(d, 1'b1, 1'b0, tag);
      if (allow) refMem[refPtr] = d;
      refPtr = pageStep(refPtr);
    end
    stopCond();
  endtask

  task automatic readSeq(input int n, input string tag);
    logic [7:0] e;
    logic last;
    sendByte(DEVR, 1'b1, ~refMem[refPtr][7], "R2");
    for (int k = 0; k < n; k++) begin
      e = refMem[refPtr];
      refPtr = (refPtr + 1) & 127;
      last = (k == n - 1);
      recvByte(~last, e, last ? 1'b0 : ~refMem[refPtr][7], tag);
    end
  endtask

  task automatic readImm(input int n, input string tag);
    startCond();
    readSeq(n, tag);
    stopCond();
  endtask

  task automatic readSel(input int addr, input int n, input string tag);
    startCond();
    sendByte(DEVW, 1'b1, 1'b0, "R8");
    sendByte(8'(addr), 1'b1, 1'b0, "R8");
    refPtr = addr & 127;
    startCond();
    readSeq(n, tag);
    stopCond();
  endtask

  initial begin
    logic seen;
    for (int i = 0; i < 128; i++) refMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (sdaOe !== 1'b0) begin
      errors++;
      $display("FAIL R10 sdaOe after reset: actual=%0b expected=0", sdaOe);
    end
    expOe = 1'b0;
    cmpEn = 1'b1;

    readImm(2, "R10");                          // R10: counter 0, array cleared
    writeTxn(DEVW, 5, 1, 8'hA5 - 0, "R4");      // byte write, R4
    readSel(5, 1, "R8");                        // R8 selective read
    writeTxn(8'hAE, 8'h1C, 18, 8'h3B, "R4");    // R2 don't-care bits, R4 page wrap
    readImm(3, "R9");                           // R9 counter persists
    readSel(8'h10, 16, "R4");                   // R4 page contents after wrap
    writeTxn(DEVW, 126, 2, 8'h81, "R6");
    writeTxn(DEVW, 0, 2, 8'hC4, "R6");
    readSel(126, 4, "R6");                      // R6 wrap 127 -> 0, R7 streaming

    // R2: mismatched device address, following byte ignored
    startCond();
    sendByte(8'h30, 1'b0, 1'b0, "R2");
    sendByte(8'h05, 1'b0, 1'b0, "R2");
    stopCond();
    readImm(1, "R2");

    // R5: protected write leaves the array unchanged
    writeTxn(DEVW, 40, 1, 8'h11, "R5");
    allow = 1'b0;
    writeTxn(DEVW, 40, 2, 8'h77, "R5");
    allow = 1'b1;
    readSel(40, 2, "R5");

    // R1: byte cut short by START is not stored
    writeTxn(DEVW, 50, 1, 8'h5A, "R1");
    startCond();
    sendByte(DEVW, 1'b1, 1'b0, "R1");
    sendByte(8'd50, 1'b1, 1'b0, "R1");
    refPtr = 50;
    for (int i = 0; i < 4; i++) clkBit(i[0], 1'b0, seen);
    startCond();
    stopCond();
    readSel(50, 1, "R1");

    // R7: after NACK the slave stays off while clocks continue
    readSel(60, 1, "R7");
    for (int i = 0; i < 9; i++) clkBit(1'b1, 1'b0, seen);
    stopCond();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule